// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast system clock into the two timing strobes a serial transmitter and receiver need: an oversampling strobe and a strobe once per serial bit. The rate comes from a divisor with a 16-bit whole part and a 6-bit fraction counted in sixty-fourths of a clock. One oversampling period lasts the whole part in clocks. A 6-bit running sum of the fraction is updated on every oversampling strobe, and each carry out of that sum adds one clock to the next period. The average period is therefore the full fractional divisor, and the error is spread evenly over the periods instead of piling up.

The bit strobe comes once per 16 oversampling strobes. When the fast-mode input is set, it comes once per 8, which doubles the bit rate for the same divisor. Software sets the divisor and the mode while the generator is disabled. The generator captures them and uses them from the moment it is enabled. Changes made while it is running have no effect. Disabling the generator clears all of its counters, so after each enable the first strobe has a known phase. A whole part of zero is illegal, and the generator stays silent while it has one captured.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released with enable low, sample_tick and bit_tick are 0.
- R2: With a fraction of 0, the first sample_tick comes in cycle W-1, where W is the captured whole part and cycle 0 is the first clock after the edge that first samples enable high. Later ticks follow every W clocks.
- R3: With fraction F (0..63), sample tick number N (counting from 1) comes in cycle N*W + floor((N-1)*F/64) - 1. Each period lasts W clocks, plus one when the previous tick carried out of the 6-bit fraction sum.
- R4: With fast mode captured as 0, bit_tick is 1 exactly together with every 16th sample_tick (ticks 16, 32, ...).
- R5: With fast mode captured as 1, bit_tick is 1 exactly together with every 8th sample_tick (ticks 8, 16, ...).
- R6: A captured whole part of 0 produces no sample_tick and no bit_tick for as long as enable stays high.
- R7: The divisor and fast-mode inputs are captured on every clock while enable is low. Changing them while enable is high does not alter the tick pattern.
- R8: One cycle after enable is sampled low, both ticks are 0. A later enable restarts the pattern from R2/R3 at cycle 0.
- R9: bit_tick is never 1 without sample_tick. When the whole part is greater than 1, two sample ticks never come in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low clears the counters and captures the settings |
| fast_mode | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| div_whole | input | 16 | Whole part of the divisor, in clocks |
| div_frac | input | 6 | Fractional part of the divisor, in 1/64 clock |
| sample_tick | output | 1 | One-clock oversampling strobe |
| bit_tick | output | 1 | One-clock strobe once per serial bit |

## Verification
The embedded assertions check on every cycle that the bit strobe never appears alone, that the period counter never runs past its limit, that the strobes stop one cycle after disable, that a zero whole part stays silent, and that strobes are spaced apart when the whole part exceeds one. The exact placement of each dithered strobe can only be shown by the bench's scenarios. So can the 16 or 8 strobe grouping, the phase after re-enable, and the fact that divisor changes made while running are ignored. The bench compares the outputs cycle by cycle against a closed-form tick schedule for random and corner divisors.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
   typedef enum logic {
      OSR_NORMAL = 1'b0,
      OSR_FAST   = 1'b1
   } osr_sel_e;

   localparam int unsigned OSR_NORMAL_RATIO = 16;
   localparam int unsigned OSR_FAST_RATIO   = 8;
endpackage

// File: rtl/frac_baud_shadow.sv
module frac_baud_shadow
   import frac_baud_pkg::*;
#(
   parameter int unsigned WHOLE_W = 16,
   parameter int unsigned FRAC_W  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               fast_in,
   input  logic [WHOLE_W-1:0] whole_in,
   input  logic [FRAC_W-1:0]  frac_in,
   output osr_sel_e           osr_q,
   output logic [WHOLE_W-1:0] whole_q,
   output logic [FRAC_W-1:0]  frac_q,
   output logic               run_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osr_q   <= OSR_NORMAL;
         whole_q <= '0;
         frac_q  <= '0;
         run_q   <= 1'b0;
      end else begin
         run_q <= enable;
         if (!enable) begin
            osr_q   <= fast_in ? OSR_FAST : OSR_NORMAL;
            whole_q <= whole_in;
            frac_q  <= frac_in;
         end
      end
   end

   // R7
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable)) |-> ($stable(whole_q) && $stable(frac_q) && $stable(osr_q)));
endmodule

// File: rtl/frac_baud_divider.sv
module frac_baud_divider #(
   parameter int unsigned WHOLE_W = 16,
   parameter int unsigned FRAC_W  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               run,
   input  logic [WHOLE_W-1:0] whole,
   input  logic [FRAC_W-1:0]  frac,
   output logic               tick
);
   localparam int unsigned CNT_W = WHOLE_W + 1;

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  last;
   logic [FRAC_W-1:0] acc;
   logic              stretch;
   logic              nonzero;
   logic [FRAC_W:0]   acc_sum;

   assign nonzero = |whole;
   assign last    = {1'b0, whole} + CNT_W'(stretch) - CNT_W'(1);
   assign tick    = run && nonzero && (cnt == last);
   assign acc_sum = {1'b0, acc} + {1'b0, frac};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         acc     <= '0;
         stretch <= 1'b0;
      end else if (!enable) begin
         cnt     <= '0;
         acc     <= '0;
         stretch <= 1'b0;
      end else if (run && nonzero) begin
         if (tick) begin
            cnt     <= '0;
            acc     <= acc_sum[FRAC_W-1:0];
            stretch <= acc_sum[FRAC_W];
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end

   // R3
   cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && nonzero) |-> (cnt <= last));
   // R6
   zero_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nonzero |-> !tick);
   // R9
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && enable && (whole > WHOLE_W'(1))) |=> !tick);
endmodule

// File: rtl/frac_baud_bitdiv.sv
module frac_baud_bitdiv
   import frac_baud_pkg::*;
#(
   parameter bit HS_EN = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     enable,
   input  osr_sel_e osr,
   input  logic     sample_tick,
   output logic     bit_tick
);
   localparam int unsigned SUB_W = $clog2(OSR_NORMAL_RATIO);

   logic [SUB_W-1:0] sub;
   logic [SUB_W-1:0] sub_last;

   generate
      if (HS_EN) begin : g_two_rates
         assign sub_last = (osr == OSR_FAST) ? SUB_W'(OSR_FAST_RATIO - 1)
                                             : SUB_W'(OSR_NORMAL_RATIO - 1);
      end else begin : g_one_rate
         assign sub_last = SUB_W'(OSR_NORMAL_RATIO - 1);
      end
   endgenerate

   assign bit_tick = sample_tick && (sub == sub_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub <= '0;
      end else if (!enable) begin
         sub <= '0;
      end else if (sample_tick) begin
         sub <= bit_tick ? '0 : sub + SUB_W'(1);
      end
   end

   // R9
   bit_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> sample_tick);
   // R4
   sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enable |-> (sub <= sub_last));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
   import frac_baud_pkg::*;
#(
   parameter int unsigned WHOLE_W = 16,
   parameter int unsigned FRAC_W  = 6,
   parameter bit          HS_EN   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               fast_mode,
   input  logic [WHOLE_W-1:0] div_whole,
   input  logic [FRAC_W-1:0]  div_frac,
   output logic               sample_tick,
   output logic               bit_tick
);
   initial begin
      if (WHOLE_W < 2) $error("WHOLE_W must be at least 2");
      if (FRAC_W < 1) $error("FRAC_W must be at least 1");
      if (OSR_FAST_RATIO >= OSR_NORMAL_RATIO) $error("fast ratio must be below normal ratio");
   end

   osr_sel_e           osr_q;
   logic [WHOLE_W-1:0] whole_q;
   logic [FRAC_W-1:0]  frac_q;
   logic               run_q;

   frac_baud_shadow #(.WHOLE_W(WHOLE_W), .FRAC_W(FRAC_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .enable(enable), .fast_in(fast_mode),
      .whole_in(div_whole), .frac_in(div_frac),
      .osr_q(osr_q), .whole_q(whole_q), .frac_q(frac_q), .run_q(run_q)
   );

   frac_baud_divider #(.WHOLE_W(WHOLE_W), .FRAC_W(FRAC_W)) u_divider (
      .clk(clk), .rst_n(rst_n), .enable(enable), .run(run_q),
      .whole(whole_q), .frac(frac_q), .tick(sample_tick)
   );

   frac_baud_bitdiv #(.HS_EN(HS_EN)) u_bitdiv (
      .clk(clk), .rst_n(rst_n), .enable(enable), .osr(osr_q),
      .sample_tick(sample_tick), .bit_tick(bit_tick)
   );

   // R8
   stop_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!sample_tick && !bit_tick));
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> (!sample_tick && !bit_tick));
endmodule

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        fast_mode = 1'b0;
   logic [15:0] div_whole = '0;
   logic [5:0]  div_frac = '0;
   logic        sample_tick, bit_tick;

   int unsigned n_checks = 0;
   int unsigned n_fail = 0;
   bit          finished = 1'b0;

   always #4 clk = ~clk;

   frac_baud_gen u_frac_baud_gen (
      .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
      .div_whole(div_whole), .div_frac(div_frac),
      .sample_tick(sample_tick), .bit_tick(bit_tick)
   );

   function automatic longint tick_cycle(longint n, longint w, longint f);
      return n * w + ((n - 1) * f) / 64 - 1;
   endfunction

   task automatic check(string req, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // Captures settings with enable low, then checks a run of 'cycles' cycles.
   // If scramble is set, the inputs are changed mid-run (R7).
   task automatic run_case(int w, int f, bit hs, int cycles, bit scramble);
      longint n = 1;
      longint nxt;
      int     ratio = hs ? 8 : 16;
      @(negedge clk);
      enable = 1'b0;
      div_whole = 16'(w);
      div_frac = 6'(f);
      fast_mode = hs;
      @(negedge clk);
      enable = 1'b1;
      nxt = (w == 0) ? -1 : tick_cycle(1, w, f);
      for (int cyc = 0; cyc < cycles; cyc++) begin
         @(negedge clk);
         if (scramble && cyc == 5) begin
            div_whole = 16'($urandom_range(1, 9));
            div_frac = 6'($urandom);
            fast_mode = ~hs;
         end
         if (w != 0 && cyc == nxt) begin
            check(hs ? "R5" : "R4", bit_tick, (n % ratio) == 0);
            check(f == 0 ? "R2" : "R3", sample_tick, 1'b1);
            n++;
            nxt = tick_cycle(n, w, f);
         end else begin
            check(w == 0 ? "R6" : (scramble ? "R7" : "R3"), sample_tick, 1'b0);
            check("R9", bit_tick, 1'b0);
         end
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1", sample_tick, 1'b0);
      check("R1", bit_tick, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", sample_tick, 1'b0);
      check("R1", bit_tick, 1'b0);

      run_case(1, 0, 1'b0, 40, 1'b0);    // R2 tick every cycle
      run_case(3, 0, 1'b0, 120, 1'b0);   // R2 R4
      run_case(2, 0, 1'b1, 60, 1'b0);    // R5
      run_case(1, 63, 1'b0, 200, 1'b0);  // R3 nearly every tick stretched
      run_case(4, 32, 1'b1, 200, 1'b0);  // R3 alternating stretch
      run_case(0, 17, 1'b0, 100, 1'b0);  // R6
      run_case(3, 21, 1'b0, 300, 1'b1);  // R7

      // R8: disable mid-run, ticks stop, re-enable is phase aligned
      run_case(2, 10, 1'b0, 37, 1'b0);
      @(negedge clk);
      enable = 1'b0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check("R8", sample_tick, 1'b0);
         check("R8", bit_tick, 1'b0);
      end
      run_case(2, 10, 1'b0, 80, 1'b0);   // R8 restart from cycle 0

      for (int t = 0; t < 25; t++) begin
         run_case($urandom_range(1, 6), $urandom_range(0, 63), 1'($urandom),
                  $urandom_range(50, 400), 1'($urandom));
      end

      @(negedge clk);
      enable = 1'b0;
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule